// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the single line reservation that one requester's load-linked and store-conditional pair relies on. It watches completions of write-class memory operations: a load-linked completion takes a reservation on its cache line, and a store-conditional completion then reports success only if that reservation is still held by the same requester. Ordinary stores to the reserved line, loss of coherence permission for that line, and the store-conditional itself all break the reservation.

Next to the monitor sits a small issue-side classifier. It maps an operation kind to the request class sent toward the coherence controller. Load-linked and store-conditional leave as the atomic class, so the protocol does not apply migratory-sharing shortcuts between them. The cache data itself is outside this block. Addresses are byte addresses, and two addresses fall on the same line when they agree above the line-offset bits.

Top module: `llsc_resv_monitor`

## Requirements
- R1: During and after reset `sc_done` is 0, `sc_ok` is 1, and no reservation is held, so the first store-conditional after any reset fails.
- R2: A completion of kind LL (3'd3) always succeeds and sets the reservation to its line and owner id, replacing any earlier reservation. It never raises `sc_done`.
- R3: A completion of kind SC (3'd4) succeeds only when the held reservation matches both its line and its owner id. One cycle later `sc_done` is 1, and `sc_ok` is 1 on success and 0 on failure. Byte offsets within a line (low log2(LINE_BYTES) bits) are ignored.
- R4: Every SC clears a reservation on its own line, whether it succeeds or fails. An SC to another line leaves the reservation intact.
- R5: A completion of kind STORE (3'd2), RMW (3'd5) or FLUSH (3'd6) to the reserved line with the reservation's owner id clears the reservation. The same completion to a different line, or with a different owner id, has no effect.
- R6: An invalidate whose line equals the reserved line clears the reservation. An invalidate of any other line has no effect.
- R7: An SC that completes in the same cycle as an invalidate of its line fails.
- R8: An LL that completes in the same cycle as an invalidate of its line still establishes its reservation.
- R9: Completions of kind LOAD (3'd0), FETCH (3'd1) or the unused code 3'd7 change neither the reservation nor the outputs.
- R10: `sc_done` is 1 for exactly the one cycle after each SC completion. Whenever `sc_done` is 0, `sc_ok` is 1.
- R11: `iss_class` is 2'd3 (atomic) for LL and SC, 2'd2 (write) for STORE, RMW and FLUSH, 2'd1 (fetch) for FETCH, and 2'd0 (read) for LOAD and 3'd7. This output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_kind | input | 3 | Kind of the operation being issued |
| iss_class | output | 2 | Downstream request class for `iss_kind` |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_kind | input | 3 | Kind of the completing operation |
| cmp_addr | input | ADDR_W | Byte address of the completing operation |
| cmp_owner | input | ID_W | Requester id of the completing operation |
| inv_valid | input | 1 | Coherence permission lost for a line this cycle |
| inv_addr | input | ADDR_W | Byte address in the line that lost permission |
| sc_done | output | 1 | A store-conditional result is presented |
| sc_ok | output | 1 | Store-conditional outcome, 1 when no result is presented |

## Verification
The checker watches four things on every cycle: the result strobe follows an SC completion by exactly one cycle, the outcome is high whenever no result is presented, a colliding invalidate forces failure, and two back-to-back SCs to one line cannot both succeed. It also checks the issue-class mapping for the atomic kinds on every cycle. Owner mismatches, ordinary stores that leave other lines alone, reservation overwrite by a second LL, and reset dropping a live reservation depend on history that spans several operations. Only the bench's scenarios show those.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_FETCH = 3'd1,
      OP_STORE = 3'd2,
      OP_LL    = 3'd3,
      OP_SC    = 3'd4,
      OP_RMW   = 3'd5,
      OP_FLUSH = 3'd6,
      OP_NONE  = 3'd7
   } op_kind_e;

   typedef enum logic [1:0] {
      CLS_READ   = 2'd0,
      CLS_FETCH  = 2'd1,
      CLS_WRITE  = 2'd2,
      CLS_ATOMIC = 2'd3
   } iss_class_e;

   typedef struct packed {
      logic is_ll;
      logic is_sc;
      logic is_plain_wr;
   } op_flags_t;

endpackage

// File: rtl/llsc_op_decode.sv
module llsc_op_decode
   import llsc_pkg::*;
(
   input  logic [2:0] kind_i,
   output logic [1:0] class_o,
   output op_flags_t  flags_o
);

   op_kind_e   kind;
   iss_class_e cls;

   assign kind = op_kind_e'(kind_i);

   always_comb begin
      flags_o = '0;
      cls     = CLS_READ;
      unique case (kind)
         OP_LL: begin
            cls           = CLS_ATOMIC;
            flags_o.is_ll = 1'b1;
         end
         OP_SC: begin
            cls           = CLS_ATOMIC;
            flags_o.is_sc = 1'b1;
         end
         OP_STORE, OP_RMW, OP_FLUSH: begin
            cls                 = CLS_WRITE;
            flags_o.is_plain_wr = 1'b1;
         end
         OP_FETCH: cls = CLS_FETCH;
         default:  cls = CLS_READ;
      endcase
   end

   assign class_o = cls;

endmodule

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
   parameter int LINE_W = 26
) (
   input  logic              qual_i,
   input  logic [LINE_W-1:0] a_i,
   input  logic [LINE_W-1:0] b_i,
   output logic              hit_o
);

   assign hit_o = qual_i && (a_i == b_i);

endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg
   import llsc_pkg::*;
#(
   parameter int LINE_W          = 26,
   parameter int ID_W            = 4,
   parameter bit STORE_OWNER_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_v_i,
   input  op_flags_t         cmp_flags_i,
   input  logic [LINE_W-1:0] cmp_line_i,
   input  logic [ID_W-1:0]   cmp_owner_i,
   input  logic              inv_v_i,
   input  logic [LINE_W-1:0] inv_line_i,
   output logic              sc_pass_o
);

   logic              resv_v_q;
   logic [LINE_W-1:0] resv_line_q;
   logic [ID_W-1:0]   resv_owner_q;

   logic cmp_on_resv;
   logic inv_on_resv;
   logic inv_on_cmp;
   logic owner_eq;
   logic store_kill;
   logic sc_kill;

   llsc_line_match #(.LINE_W(LINE_W)) u_cmp_vs_resv (
      .qual_i (resv_v_q),
      .a_i    (resv_line_q),
      .b_i    (cmp_line_i),
      .hit_o  (cmp_on_resv)
   );

   llsc_line_match #(.LINE_W(LINE_W)) u_inv_vs_resv (
      .qual_i (resv_v_q && inv_v_i),
      .a_i    (resv_line_q),
      .b_i    (inv_line_i),
      .hit_o  (inv_on_resv)
   );

   llsc_line_match #(.LINE_W(LINE_W)) u_inv_vs_cmp (
      .qual_i (inv_v_i),
      .a_i    (inv_line_i),
      .b_i    (cmp_line_i),
      .hit_o  (inv_on_cmp)
   );

   assign owner_eq  = (resv_owner_q == cmp_owner_i);
   assign sc_kill   = cmp_v_i && cmp_flags_i.is_sc && cmp_on_resv;
   assign sc_pass_o = sc_kill && owner_eq && !inv_on_cmp;

   generate
      if (STORE_OWNER_CHK) begin : g_store_owned
         assign store_kill = cmp_v_i && cmp_flags_i.is_plain_wr && cmp_on_resv && owner_eq;
      end else begin : g_store_any
         assign store_kill = cmp_v_i && cmp_flags_i.is_plain_wr && cmp_on_resv;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_v_q     <= 1'b0;
         resv_line_q  <= '0;
         resv_owner_q <= '0;
      end else if (cmp_v_i && cmp_flags_i.is_ll) begin
         resv_v_q     <= 1'b1;
         resv_line_q  <= cmp_line_i;
         resv_owner_q <= cmp_owner_i;
      end else if (inv_on_resv || sc_kill || store_kill) begin
         resv_v_q     <= 1'b0;
      end
   end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
   import llsc_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int LINE_BYTES      = 64,
   parameter int ID_W            = 4,
   parameter bit STORE_OWNER_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        iss_kind,
   output logic [1:0]        iss_class,
   input  logic              cmp_valid,
   input  logic [2:0]        cmp_kind,
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic [ID_W-1:0]   cmp_owner,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              sc_done,
   output logic              sc_ok
);

   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFS_W;

   generate
      if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 2");
      end
      if (LINE_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed the line offset width");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("ID_W must be at least 1");
      end
   endgenerate

   op_flags_t iss_flags_unused;
   op_flags_t cmp_flags;
   logic [1:0] cmp_class_unused;
   logic      sc_pass;
   logic      sc_done_q;
   logic      sc_ok_q;

   llsc_op_decode u_iss_dec (
      .kind_i  (iss_kind),
      .class_o (iss_class),
      .flags_o (iss_flags_unused)
   );

   llsc_op_decode u_cmp_dec (
      .kind_i  (cmp_kind),
      .class_o (cmp_class_unused),
      .flags_o (cmp_flags)
   );

   llsc_resv_reg #(
      .LINE_W          (LINE_W),
      .ID_W            (ID_W),
      .STORE_OWNER_CHK (STORE_OWNER_CHK)
   ) u_resv (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_v_i     (cmp_valid),
      .cmp_flags_i (cmp_flags),
      .cmp_line_i  (cmp_addr[ADDR_W-1:OFS_W]),
      .cmp_owner_i (cmp_owner),
      .inv_v_i     (inv_valid),
      .inv_line_i  (inv_addr[ADDR_W-1:OFS_W]),
      .sc_pass_o   (sc_pass)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_done_q <= 1'b0;
         sc_ok_q   <= 1'b1;
      end else begin
         sc_done_q <= cmp_valid && cmp_flags.is_sc;
         sc_ok_q   <= (cmp_valid && cmp_flags.is_sc) ? sc_pass : 1'b1;
      end
   end

   assign sc_done = sc_done_q;
   assign sc_ok   = sc_ok_q;

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int ID_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        iss_kind,
   input logic [1:0]        iss_class,
   input logic              cmp_valid,
   input logic [2:0]        cmp_kind,
   input logic [ADDR_W-1:0] cmp_addr,
   input logic [ID_W-1:0]   cmp_owner,
   input logic              inv_valid,
   input logic [ADDR_W-1:0] inv_addr,
   input logic              sc_done,
   input logic              sc_ok
);

   localparam int OFS_W = $clog2(LINE_BYTES);

   logic is_sc_cmp;
   logic same_line_inv;

   assign is_sc_cmp     = cmp_valid && (cmp_kind == 3'd4);
   assign same_line_inv = inv_valid && (inv_addr[ADDR_W-1:OFS_W] == cmp_addr[ADDR_W-1:OFS_W]);

   assert_sc_done_follows_sc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_sc_cmp |=> sc_done);

   assert_done_needs_sc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_sc_cmp |=> !sc_done);

   assert_ok_high_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_done |-> sc_ok);

   assert_inv_collision_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc_cmp && same_line_inv) |=> (sc_done && !sc_ok));

   assert_second_sc_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc_cmp && $past(is_sc_cmp) &&
       ($past(cmp_addr[ADDR_W-1:OFS_W]) == cmp_addr[ADDR_W-1:OFS_W])) |=> !sc_ok);

   assert_atomic_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_kind == 3'd3 || iss_kind == 3'd4) |-> (iss_class == 2'd3));

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .ID_W       (ID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_kind  (iss_kind),
   .iss_class (iss_class),
   .cmp_valid (cmp_valid),
   .cmp_kind  (cmp_kind),
   .cmp_addr  (cmp_addr),
   .cmp_owner (cmp_owner),
   .inv_valid (inv_valid),
   .inv_addr  (inv_addr),
   .sc_done   (sc_done),
   .sc_ok     (sc_ok)
);

// File: tb/llsc_resv_monitor_bench.sv
module llsc_resv_monitor_bench;

   localparam logic [31:0] LA  = 32'h0000_1000;
   localparam logic [31:0] LA8 = 32'h0000_1008;
   localparam logic [31:0] LB  = 32'h0000_2000;
   localparam logic [31:0] NA  = 32'h0;

   typedef struct packed {
      logic        inv_v;
      logic [31:0] inv_a;
      logic        cmp_v;
      logic [2:0]  kind;
      logic [31:0] addr;
      logic [3:0]  owner;
      logic        exp_done;
      logic        exp_ok;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VECS [NV] = '{
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},  // R2 LL A
      '{1'b0, NA, 1'b1, 3'd4, LA8, 4'd1, 1'b1, 1'b1, 8'd3},  // R3 SC A+8 passes
      '{1'b0, NA, 1'b0, 3'd0, NA,  4'd0, 1'b0, 1'b1, 8'd10}, // R10 idle after SC
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd4},  // R4 SC cleared lock
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},  // R2
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd2, 1'b1, 1'b0, 8'd3},  // R3 owner mismatch
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd4},  // R4 failed SC cleared
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd2, LA,  4'd1, 1'b0, 1'b1, 8'd5},  // R5 store A
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd5},  // R5 store cleared
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd2, LB,  4'd1, 1'b0, 1'b1, 8'd5},  // R5 store B
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b1, 8'd5},  // R5 other line kept
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd2, LA,  4'd2, 1'b0, 1'b1, 8'd5},  // R5 other owner
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b1, 8'd5},  // R5 kept
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd5, LA8, 4'd1, 1'b0, 1'b1, 8'd5},  // R5 RMW A
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd5},
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b1, LB, 1'b0, 3'd0, NA,  4'd0, 1'b0, 1'b1, 8'd6},  // R6 inv B
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b1, 8'd6},
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b1, LA8,1'b0, 3'd0, NA,  4'd0, 1'b0, 1'b1, 8'd6},  // R6 inv A
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd6},
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b1, LA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd7},  // R7 collision
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd3, LB,  4'd1, 1'b0, 1'b1, 8'd2},  // R2 overwrite
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b0, 8'd2},
      '{1'b0, NA, 1'b1, 3'd4, LB,  4'd1, 1'b1, 1'b1, 8'd4},  // R4 SC A left B
      '{1'b1, LA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd8},  // R8 inv+LL
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b1, 8'd8},
      '{1'b0, NA, 1'b1, 3'd3, LA,  4'd1, 1'b0, 1'b1, 8'd2},
      '{1'b0, NA, 1'b1, 3'd0, LA,  4'd1, 1'b0, 1'b1, 8'd9},  // R9 load
      '{1'b0, NA, 1'b1, 3'd7, LA,  4'd1, 1'b0, 1'b1, 8'd9},  // R9 unused code
      '{1'b0, NA, 1'b1, 3'd1, LA,  4'd1, 1'b0, 1'b1, 8'd9},  // R9 fetch
      '{1'b0, NA, 1'b1, 3'd4, LA,  4'd1, 1'b1, 1'b1, 8'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  iss_kind;
   logic [1:0]  iss_class;
   logic        cmp_valid;
   logic [2:0]  cmp_kind;
   logic [31:0] cmp_addr;
   logic [3:0]  cmp_owner;
   logic        inv_valid;
   logic [31:0] inv_addr;
   logic        sc_done;
   logic        sc_ok;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #5 clk = ~clk;

   llsc_resv_monitor u_llsc_resv_monitor (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_kind  (iss_kind),
      .iss_class (iss_class),
      .cmp_valid (cmp_valid),
      .cmp_kind  (cmp_kind),
      .cmp_addr  (cmp_addr),
      .cmp_owner (cmp_owner),
      .inv_valid (inv_valid),
      .inv_addr  (inv_addr),
      .sc_done   (sc_done),
      .sc_ok     (sc_ok)
   );

   task automatic check_out(input string req, input logic ed, input logic eo);
      checks++;
      if (sc_done !== ed || sc_ok !== eo) begin
         fails++;
         $display("FAIL %s: done/ok actual %b%b expected %b%b", req, sc_done, sc_ok, ed, eo);
      end
   endtask

   task automatic drive(input logic iv, input logic [31:0] ia, input logic cv,
                        input logic [2:0] k, input logic [31:0] a, input logic [3:0] o);
      inv_valid = iv;
      inv_addr  = ia;
      cmp_valid = cv;
      cmp_kind  = k;
      cmp_addr  = a;
      cmp_owner = o;
      @(posedge clk);
      @(negedge clk);
      inv_valid = 1'b0;
      cmp_valid = 1'b0;
   endtask

   function automatic logic [1:0] exp_class(input logic [2:0] k);
      case (k)
         3'd3, 3'd4:       return 2'd3;
         3'd2, 3'd5, 3'd6: return 2'd2;
         3'd1:             return 2'd1;
         default:          return 2'd0;
      endcase
   endfunction

   initial begin
      #(200000 * 10);
      if (!ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      iss_kind = 3'd0;
      cmp_valid = 1'b0; cmp_kind = 3'd0; cmp_addr = '0; cmp_owner = '0;
      inv_valid = 1'b0; inv_addr = '0;
      @(posedge clk);
      @(negedge clk);
      check_out("R1 in reset", 1'b0, 1'b1);
      rst_n = 1'b1;
      drive(1'b0, NA, 1'b1, 3'd4, LA, 4'd1);
      check_out("R1 no reservation after reset", 1'b1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].inv_v, VECS[i].inv_a, VECS[i].cmp_v, VECS[i].kind,
               VECS[i].addr, VECS[i].owner);
         checks++;
         if (sc_done !== VECS[i].exp_done || sc_ok !== VECS[i].exp_ok) begin
            fails++;
            $display("FAIL R%0d vector %0d: done/ok actual %b%b expected %b%b",
                     VECS[i].req, i, sc_done, sc_ok, VECS[i].exp_done, VECS[i].exp_ok);
         end
      end

      // R1: reset drops a live reservation
      drive(1'b0, NA, 1'b1, 3'd3, LA, 4'd1);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_out("R1 reset mid-run", 1'b0, 1'b1);
      rst_n = 1'b1;
      drive(1'b0, NA, 1'b1, 3'd4, LA, 4'd1);
      check_out("R1 reservation lost on reset", 1'b1, 1'b0);

      // R10: one-cycle strobe, ok high when idle
      drive(1'b0, NA, 1'b0, 3'd0, NA, 4'd0);
      check_out("R10 strobe drops", 1'b0, 1'b1);

      // R4: failed SC leaves a reservation on another line
      drive(1'b0, NA, 1'b1, 3'd3, LB, 4'd3);
      drive(1'b0, NA, 1'b1, 3'd4, LA, 4'd3);
      check_out("R4 SC other line", 1'b1, 1'b0);
      drive(1'b0, NA, 1'b1, 3'd4, LB, 4'd3);
      check_out("R3 owner 3 success", 1'b1, 1'b1);

      // R5: flush clears
      drive(1'b0, NA, 1'b1, 3'd3, LB, 4'd3);
      drive(1'b0, NA, 1'b1, 3'd6, LB, 4'd3);
      drive(1'b0, NA, 1'b1, 3'd4, LB, 4'd3);
      check_out("R5 flush cleared", 1'b1, 1'b0);

      // R11: issue class for every kind
      for (int k = 0; k < 8; k++) begin
         iss_kind = k[2:0];
         #1;
         checks++;
         if (iss_class !== exp_class(k[2:0])) begin
            fails++;
            $display("FAIL R11 kind %0d: actual %0d expected %0d", k, iss_class, exp_class(k[2:0]));
         end
      end

      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule